// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block is a packed-arithmetic unit for a 32-bit datapath. Each operand can be read in one of three lane formats: two signed Q15 halfwords, four unsigned bytes, or one signed Q31 word. For each format the unit adds or subtracts lane by lane. Halfword and word lanes can also take an absolute value. Every one of these operations comes in a wrapping flavour and a clamping flavour. One further operation adds the four unsigned bytes of the first operand into a single zero-extended word.

A five-bit operation code selects the operation. The 32-bit result and a single overflow flag are produced together. The overflow flag reports whether any lane went out of range, whichever flavour was chosen. A parameter places a register on the outputs. With the default setting, the result of an input set is available after the next rising clock edge.

Top module: `simd_sat_alu`

## Requirements
- R1: Operation codes: bit 0 selects clamping for codes 0 to 15. Codes 0/1 are halfword add, 2/3 halfword subtract, 4/5 byte add, 6/7 byte subtract, 8/9 word add, 10/11 word subtract, 12/13 halfword absolute value, 14/15 word absolute value, and 16 is the byte reduction. Codes 17 to 31 give result 0 with the overflow flag low.
- R2: Halfword lanes are the signed values in bits 15:0 and 31:16. Add and subtract wrap modulo 2^16. In clamping mode a lane that overflows becomes 0x7fff, and a lane that underflows becomes 0x8000 (0x1234+0x6f89 gives 0x81bd wrapped and 0x7fff clamped; 0x8000-0x6f89 clamped gives 0x8000).
- R3: Byte lanes are the unsigned values in bits 8k+7:8k, for k from 0 to 3. Add and subtract wrap modulo 256. In clamping mode an add clamps at 0xff and a subtract clamps at 0x00 (0xf2+0xff gives 0xf1 or 0xff; 0xf2-0xff clamped gives 0x00).
- R4: The word lane is a signed 32-bit value. Add and subtract wrap modulo 2^32. In clamping mode the lane limits are 0x7fffffff and 0x80000000 (0x70000000+0x71234567 clamped gives 0x7fffffff).
- R5: Absolute value on halfword and word lanes uses only the first operand. Clamping mode maps the most negative value to the most positive value (0x8000 to 0x7fff, 0x80000000 to 0x7fffffff). Wrapping mode leaves the most negative value unchanged. Lane 0x8134 becomes 0x7ecc.
- R6: The byte reduction returns the sum of the four bytes of the first operand, zero-extended to 32 bits, with the overflow flag low (bytes f2, 34, 56, 78 give 0x1f4).
- R7: No carry or borrow passes from one lane into another.
- R8: The overflow flag is high exactly when at least one lane's exact result falls outside the range of its format, in both wrapping and clamping modes.
- R9: With the output register enabled, the result and flag change only at a rising clock edge and show the inputs sampled at that edge. An active-low asynchronous reset sets both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| opCode | input | 5 | Operation select |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand (ignored by absolute value and reduction) |
| result | output | 32 | Packed result |
| overflow | output | 1 | Any lane out of range |

## Verification
With the default output register, a result and its flag are due one rising edge after the operands and operation code are applied. The bench therefore changes inputs on a falling edge and compares on the next falling edge. A separate check samples the outputs just after new inputs are driven, before the edge, and confirms that the previous result is still held. Reset is checked a few nanoseconds after it is asserted, without waiting for a clock edge, because it acts asynchronously. The sweep crosses every operation code with operands built from lane edge values, and an arithmetic model in the bench computes each expected value.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_ADD_PH  = 5'd0;
  localparam logic [OP_W-1:0] OP_ADDS_PH = 5'd1;
  localparam logic [OP_W-1:0] OP_SUB_PH  = 5'd2;
  localparam logic [OP_W-1:0] OP_SUBS_PH = 5'd3;
  localparam logic [OP_W-1:0] OP_ADD_QB  = 5'd4;
  localparam logic [OP_W-1:0] OP_ADDS_QB = 5'd5;
  localparam logic [OP_W-1:0] OP_SUB_QB  = 5'd6;
  localparam logic [OP_W-1:0] OP_SUBS_QB = 5'd7;
  localparam logic [OP_W-1:0] OP_ADD_W   = 5'd8;
  localparam logic [OP_W-1:0] OP_ADDS_W  = 5'd9;
  localparam logic [OP_W-1:0] OP_SUB_W   = 5'd10;
  localparam logic [OP_W-1:0] OP_SUBS_W  = 5'd11;
  localparam logic [OP_W-1:0] OP_ABS_PH  = 5'd12;
  localparam logic [OP_W-1:0] OP_ABSS_PH = 5'd13;
  localparam logic [OP_W-1:0] OP_ABS_W   = 5'd14;
  localparam logic [OP_W-1:0] OP_ABSS_W  = 5'd15;
  localparam logic [OP_W-1:0] OP_RADD_QB = 5'd16;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_HALF = 3'd1,
    FMT_BYTE = 3'd2,
    FMT_WORD = 3'd3,
    FMT_RED  = 3'd4
  } laneFmt_e;

  typedef struct packed {
    laneFmt_e fmt;
    logic     isSub;
    logic     isAbs;
    logic     sat;
  } aluCtrl_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{fmt: FMT_NONE, isSub: 1'b0, isAbs: 1'b0, sat: 1'b0};
    if (opCode[OP_W-1]) begin
      if (opCode == OP_RADD_QB) ctrl.fmt = FMT_RED;
    end else begin
      ctrl.sat = opCode[0];
      unique case (opCode[3:2])
        2'b00: begin ctrl.fmt = FMT_HALF; ctrl.isSub = opCode[1]; end
        2'b01: begin ctrl.fmt = FMT_BYTE; ctrl.isSub = opCode[1]; end
        2'b10: begin ctrl.fmt = FMT_WORD; ctrl.isSub = opCode[1]; end
        default: begin
          ctrl.fmt   = opCode[1] ? FMT_WORD : FMT_HALF;
          ctrl.isAbs = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W           = 16,
  parameter bit SIGNED_LANE = 1'b1
) (
  input  logic [W-1:0] laneA,
  input  logic [W-1:0] laneB,
  input  logic         isSub,
  input  logic         isAbs,
  input  logic         sat,
  output logic [W-1:0] laneRes,
  output logic         laneOvf
);

  localparam int EW = W + 1;

  logic [EW-1:0] aExt, bExt, xOp, yOp, sumE;
  logic [W-1:0]  satVal;
  logic          doSub;

  assign aExt = SIGNED_LANE ? {laneA[W-1], laneA} : {1'b0, laneA};
  assign bExt = SIGNED_LANE ? {laneB[W-1], laneB} : {1'b0, laneB};

  // absolute value reuses the adder as 0 +/- a
  always_comb begin
    xOp   = isAbs ? '0 : aExt;
    yOp   = isAbs ? aExt : bExt;
    doSub = isAbs ? (SIGNED_LANE && laneA[W-1]) : isSub;
    sumE  = doSub ? (xOp - yOp) : (xOp + yOp);
  end

  generate
    if (SIGNED_LANE) begin : gSigned
      assign laneOvf = sumE[W] ^ sumE[W-1];
      assign satVal  = sumE[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin : gUnsigned
      assign laneOvf = sumE[W];
      assign satVal  = doSub ? {W{1'b0}} : {W{1'b1}};
    end
  endgenerate

  assign laneRes = (laneOvf && sat) ? satVal : sumE[W-1:0];

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resComb,
  output logic              ovfComb
);

  localparam int NUM_HALF = 2;
  localparam int NUM_BYTE = 4;
  localparam int HALF_W   = DATA_W / NUM_HALF;
  localparam int BYTE_W   = DATA_W / NUM_BYTE;
  localparam int RED_W    = BYTE_W + $clog2(NUM_BYTE);

  logic [DATA_W-1:0]   halfRes, byteRes, wordRes, redRes;
  logic [NUM_HALF-1:0] halfOvf;
  logic [NUM_BYTE-1:0] byteOvf;
  logic                wordOvf;
  logic [RED_W-1:0]    redSum;

  generate
    for (genvar g = 0; g < NUM_HALF; g++) begin : gHalf
      simd_lane #(.W(HALF_W), .SIGNED_LANE(1'b1)) uLane (
        .laneA  (opA[g*HALF_W +: HALF_W]),
        .laneB  (opB[g*HALF_W +: HALF_W]),
        .isSub  (ctrl.isSub),
        .isAbs  (ctrl.isAbs),
        .sat    (ctrl.sat),
        .laneRes(halfRes[g*HALF_W +: HALF_W]),
        .laneOvf(halfOvf[g])
      );
    end
    for (genvar g = 0; g < NUM_BYTE; g++) begin : gByte
      simd_lane #(.W(BYTE_W), .SIGNED_LANE(1'b0)) uLane (
        .laneA  (opA[g*BYTE_W +: BYTE_W]),
        .laneB  (opB[g*BYTE_W +: BYTE_W]),
        .isSub  (ctrl.isSub),
        .isAbs  (1'b0),
        .sat    (ctrl.sat),
        .laneRes(byteRes[g*BYTE_W +: BYTE_W]),
        .laneOvf(byteOvf[g])
      );
    end
  endgenerate

  simd_lane #(.W(DATA_W), .SIGNED_LANE(1'b1)) uWord (
    .laneA  (opA),
    .laneB  (opB),
    .isSub  (ctrl.isSub),
    .isAbs  (ctrl.isAbs),
    .sat    (ctrl.sat),
    .laneRes(wordRes),
    .laneOvf(wordOvf)
  );

  always_comb begin
    redSum = '0;
    for (int i = 0; i < NUM_BYTE; i++) begin
      redSum = redSum + RED_W'(opA[i*BYTE_W +: BYTE_W]);
    end
    redRes = DATA_W'(redSum);
  end

  always_comb begin
    unique case (ctrl.fmt)
      FMT_HALF: begin resComb = halfRes; ovfComb = |halfOvf; end
      FMT_BYTE: begin resComb = byteRes; ovfComb = |byteOvf; end
      FMT_WORD: begin resComb = wordRes; ovfComb = wordOvf;  end
      FMT_RED:  begin resComb = redRes;  ovfComb = 1'b0;     end
      default:  begin resComb = '0;      ovfComb = 1'b0;     end
    endcase
  end

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              overflow
);

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] resComb;
  logic              ovfComb;

  simd_ctrl uCtrl (
    .opCode(opCode),
    .ctrl  (ctrl)
  );

  simd_datapath #(.DATA_W(DATA_W)) uDp (
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .resComb(resComb),
    .ovfComb(ovfComb)
  );

  generate
    if (OUT_REG) begin : gReg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result   <= '0;
          overflow <= 1'b0;
        end else begin
          result   <= resComb;
          overflow <= ovfComb;
        end
      end
    end else begin : gComb
      assign result   = resComb;
      assign overflow = ovfComb;
    end
  endgenerate

endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk
  import simd_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic              overflow
);

  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;
  localparam int RED_W  = BYTE_W + 2;
  localparam logic [DATA_W-1:0] WMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] WMIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [OP_W-1:0]   opQ;
  logic [DATA_W-1:0] aQ, bQ;

  generate
    if (OUT_REG) begin : gCap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          opQ <= '0; aQ <= '0; bQ <= '0;
        end else begin
          opQ <= opCode; aQ <= opA; bQ <= opB;
        end
      end
    end else begin : gDir
      assign opQ = opCode;
      assign aQ  = opA;
      assign bQ  = opB;
    end
  endgenerate

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (opQ > OP_RADD_QB) |-> (result == '0 && !overflow)); // R1

  AST_HALF_SAT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (opQ == OP_ADDS_PH && !overflow) |->
      (result == {aQ[DATA_W-1:HALF_W] + bQ[DATA_W-1:HALF_W], aQ[HALF_W-1:0] + bQ[HALF_W-1:0]})); // R2

  generate
    for (genvar g = 0; g < 4; g++) begin : gFloor
      AST_BYTE_SUB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (opQ == OP_SUBS_QB) |-> (result[g*BYTE_W +: BYTE_W] <= aQ[g*BYTE_W +: BYTE_W])); // R3
    end
  endgenerate

  AST_WORD_WRAP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (opQ == OP_ADD_W) |-> (result == aQ + bQ)); // R4

  AST_WORD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (opQ == OP_ADDS_W && overflow) |-> (result == WMAX || result == WMIN)); // R4

  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (opQ == OP_ABSS_W) |-> !result[DATA_W-1]); // R5

  AST_REDUCE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (opQ == OP_RADD_QB) |-> (result[DATA_W-1:RED_W] == '0 && !overflow)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (opQ == OP_ADD_W) |->
      (overflow == (aQ[DATA_W-1] == bQ[DATA_W-1] && result[DATA_W-1] != aQ[DATA_W-1]))); // R8

endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) uChk (.*);

// File: tb/simd_sat_alu_test.sv
`timescale 1ns/1ps
module simd_sat_alu_test;

  localparam time HALF_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opCode = 5'd0;
  logic [31:0] opA = 32'h0, opB = 32'h0;
  logic [31:0] result;
  logic        overflow;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  simd_sat_alu uut (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .opA(opA), .opB(opB),
    .result(result), .overflow(overflow)
  );

  always #(HALF_PERIOD) clk = ~clk;

  // arithmetic reference: {overflow, result}
  function automatic logic [32:0] refModel(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic o;
    longint x, y, e;
    r = 32'h0; o = 1'b0;
    if (op < 5'd4 || op == 5'd12 || op == 5'd13) begin
      for (int k = 0; k < 2; k++) begin
        x = longint'($signed(a[k*16 +: 16]));
        y = longint'($signed(b[k*16 +: 16]));
        if (op >= 5'd12) e = (x < 0) ? -x : x;
        else e = op[1] ? x - y : x + y;
        if (e > 32767) begin o = 1'b1; if (op[0]) e = 32767; end
        else if (e < -32768) begin o = 1'b1; if (op[0]) e = -32768; end
        r[k*16 +: 16] = e[15:0];
      end
    end else if (op < 5'd8) begin
      for (int k = 0; k < 4; k++) begin
        x = longint'({56'h0, a[k*8 +: 8]});
        y = longint'({56'h0, b[k*8 +: 8]});
        e = op[1] ? x - y : x + y;
        if (e > 255) begin o = 1'b1; if (op[0]) e = 255; end
        else if (e < 0) begin o = 1'b1; if (op[0]) e = 0; end
        r[k*8 +: 8] = e[7:0];
      end
    end else if (op < 5'd12 || op == 5'd14 || op == 5'd15) begin
      x = longint'($signed(a));
      y = longint'($signed(b));
      if (op >= 5'd14) e = (x < 0) ? -x : x;
      else e = op[1] ? x - y : x + y;
      if (e > 64'sd2147483647) begin o = 1'b1; if (op[0]) e = 64'sd2147483647; end
      else if (e < -64'sd2147483648) begin o = 1'b1; if (op[0]) e = -64'sd2147483648; end
      r = e[31:0];
    end else if (op == 5'd16) begin
      r = {24'h0, a[7:0]} + {24'h0, a[15:8]} + {24'h0, a[23:16]} + {24'h0, a[31:24]};
    end
    return {o, r};
  endfunction

  function automatic string reqFor(input logic [4:0] op);
    if (op < 5'd4) return "R2";
    if (op < 5'd8) return "R3";
    if (op < 5'd12) return "R4";
    if (op < 5'd16) return "R5";
    if (op == 5'd16) return "R6";
    return "R1";
  endfunction

  function automatic logic [15:0] edgeHalf(input int i);
    case (i & 15)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h7fff;  3: return 16'h8000;
      4: return 16'h8001;  5: return 16'hffff;  6: return 16'h7ffe;  7: return 16'h00ff;
      8: return 16'h0100;  9: return 16'h1234; 10: return 16'h6f89; 11: return 16'h5678;
      12: return 16'h1111; 13: return 16'hf234; 14: return 16'h8134; default: return 16'h4000;
    endcase
  endfunction

  function automatic logic [31:0] pattern(input int i);
    logic [15:0] lo, hi;
    lo = edgeHalf(i);
    hi = edgeHalf(i * 5 + 3);
    return (i >= 16) ? {lo, hi} : {hi, lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input logic actO, input logic expO);
    vectors++;
    if (act !== exp || actO !== expO) begin
      miscompares++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h/%b expected=%h/%b",
               req, opCode, opA, opB, act, actO, exp, expO);
    end
  endtask

  task automatic applyVec(input string req, input logic [4:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] exp, input logic expO);
    opCode = op; opA = a; opB = b;
    @(negedge clk);
    check(req, result, exp, overflow, expO);
  endtask

  initial begin
    logic [32:0] m;
    logic [31:0] held;
    opCode = 5'd8; opA = 32'h1234_5678; opB = 32'h0f0f_0f0f;
    repeat (3) @(negedge clk);
    check("R9 reset", result, 32'h0, overflow, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // stated values
    applyVec("R2", 5'd0,  32'h5678_1234, 32'h1111_6f89, 32'h6789_81bd, 1'b1);
    applyVec("R2", 5'd1,  32'h5678_1234, 32'h1111_6f89, 32'h6789_7fff, 1'b1);
    applyVec("R2", 5'd3,  32'h5678_8000, 32'h1111_6f89, 32'h4567_8000, 1'b1);
    applyVec("R3", 5'd4,  32'h7856_34f2, 32'h1111_89ff, 32'h8967_bdf1, 1'b1);
    applyVec("R3", 5'd5,  32'h7856_34f2, 32'h1111_89ff, 32'h8967_bdff, 1'b1);
    applyVec("R3", 5'd7,  32'h7856_34f2, 32'h1111_89ff, 32'h6745_0000, 1'b1);
    applyVec("R4", 5'd9,  32'h7000_0000, 32'h7123_4567, 32'h7fff_ffff, 1'b1);
    applyVec("R4", 5'd11, 32'h7000_0000, 32'h7123_4567, 32'hfedc_ba99, 1'b0);
    applyVec("R5", 5'd13, 32'h8134_8000, 32'hdead_beef, 32'h7ecc_7fff, 1'b1);
    applyVec("R5", 5'd15, 32'h8000_0000, 32'h0000_0000, 32'h7fff_ffff, 1'b1);
    applyVec("R5", 5'd14, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1);
    applyVec("R6", 5'd16, 32'h7856_34f2, 32'hffff_ffff, 32'h0000_01f4, 1'b0);
    applyVec("R1", 5'd23, 32'hffff_ffff, 32'hffff_ffff, 32'h0000_0000, 1'b0);
    applyVec("R7", 5'd4,  32'h00ff_00ff, 32'h0001_0001, 32'h0000_0000, 1'b1);
    applyVec("R7", 5'd0,  32'h0000_ffff, 32'h0000_0001, 32'h0000_0000, 1'b0);
    applyVec("R8", 5'd6,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0);

    // latency: output holds old value until the edge
    applyVec("R9", 5'd8, 32'h0000_0001, 32'h0000_0001, 32'h0000_0002, 1'b0);
    held = result;
    opCode = 5'd8; opA = 32'h0000_0010; opB = 32'h0000_0020;
    #1ns;
    check("R9 hold", result, held, overflow, 1'b0);
    @(negedge clk);
    check("R9 update", result, 32'h0000_0030, overflow, 1'b0);

    // near-exhaustive sweep
    for (int o = 0; o < 19; o++) begin
      for (int ia = 0; ia < 32; ia++) begin
        for (int ib = 0; ib < 32; ib++) begin
          logic [4:0] op;
          op = (o == 18) ? 5'd31 : 5'(o);
          opCode = op; opA = pattern(ia); opB = pattern(ib + 7);
          m = refModel(op, opA, opB);
          @(negedge clk);
          check(reqFor(op), result, m[31:0], m[32], m[32]);
          check("R8", 32'h0, 32'h0, overflow, m[32]);
        end
      end
    end

    // asynchronous reset mid-run
    opCode = 5'd9; opA = 32'h7000_0000; opB = 32'h7000_0000;
    @(negedge clk);
    #2ns rst_n = 1'b0;
    #2ns check("R9 async reset", result, 32'h0, overflow, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(HALF_PERIOD * 2 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule